// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands in the common single-precision layout: a sign bit, an 8-bit biased exponent and a 23-bit fraction. It is fully pipelined. A fresh operand pair may be presented on every rising clock edge, and each product comes out a fixed seven clocks later, in the order the operands went in. Three status flags travel with every product: overflow, underflow and invalid operation.

Each operand is first sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. The classes go to a small control path, which decides whether the result is forced to a NaN, an infinity or a zero. The datapath does the real arithmetic. It unpacks both operands, normalizes subnormal significands, forms the exponent sum and the 48-bit significand product, renormalizes, shifts tiny results right into the subnormal range, and rounds to nearest with ties to even. The final stage merges the arithmetic result with the control decision and registers the result word and the flags.

Top module: `fp32_mul_pipe`

## Requirements
- R1: The product of an operand pair captured at a rising edge appears on the outputs after the seventh rising edge counted from that one. A new pair is accepted on every edge, and results leave in input order.
- R2: For finite nonzero operands whose product is within the normal range, the result is the exact product rounded to nearest, with ties going to the even fraction, and no flag is raised.
- R3: The result sign is the XOR of the two operand signs whenever the result is a number, a zero or an infinity.
- R4: Subnormal operands are multiplied at their true value. A product that lands in the normal range is returned as a normal number.
- R5: A product below the normal range is shifted right before rounding and returned as a subnormal or a signed zero. The underflow flag is raised exactly when the rounded result has an exponent field of zero and the rounding was inexact. A tiny product that rounds up to the smallest normal number does not raise underflow.
- R6: A finite product whose rounded magnitude reaches 2^128 returns an infinity carrying the XOR sign (exponent field all ones, fraction zero) and raises overflow only.
- R7: Any NaN operand gives the canonical quiet NaN 0x7FC00000. A NaN with fraction bit 22 at zero is signaling and raises invalid. A NaN with fraction bit 22 at one is quiet and raises no flag.
- R8: Zero times infinity, in either order and with any signs, gives 0x7FC00000 and raises invalid.
- R9: Infinity times a nonzero non-NaN operand gives a signed infinity, and zero times a finite operand gives a signed zero, both with no flag.
- R10: While reset is low, the result word and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 32 | First operand, single-precision layout |
| bIn | input | 32 | Second operand, single-precision layout |
| productOut | output | 32 | Rounded product |
| overflowOut | output | 1 | Overflow flag for the product on productOut |
| underflowOut | output | 1 | Underflow flag for the product on productOut |
| invalidOut | output | 1 | Invalid-operation flag for the product on productOut |

## Verification
The bench uses the default widths: 8 exponent bits and 23 fraction bits. With these values every stimulus and expected result can be written as an exact 32-bit hex word, worked out by hand from powers of two. That puts the edge cases on exact bit patterns: the smallest subnormal, the smallest normal, the largest finite value and the ties that round to even. With this exponent width a product of two smallest subnormals falls 149 places below the smallest subnormal. That is far past the 48-bit significand, so the clamped right shift and the sticky path are exercised at their limit. The table is streamed back to back, so the seven-stage alignment of results and flags is checked at full throughput.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fpClass_e;

  // Result-override strobes sent from control to datapath
  typedef struct packed {
    logic forceNan;
    logic forceInf;
    logic forceZero;
    logic raiseInvalid;
  } fpStrobe_t;

  localparam int PIPE_DEPTH = 7;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] magIn,
  output fpClass_e                opClass
);

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  assign expField  = magIn[EXP_W+FRAC_W-1 -: EXP_W];
  assign fracField = magIn[FRAC_W-1:0];

  always_comb begin
    if (expField == '0)
      opClass = (fracField == '0) ? CLS_ZERO : CLS_SUB;
    else if (expField == '1) begin
      if (fracField == '0)           opClass = CLS_INF;
      else if (fracField[FRAC_W-1])  opClass = CLS_QNAN;
      else                           opClass = CLS_SNAN;
    end else
      opClass = CLS_NORM;
  end

endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int STAGES = PIPE_DEPTH - 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  fpClass_e  classA,
  input  fpClass_e  classB,
  output fpStrobe_t strobeOut
);

  logic      anyNan, anySnan, anyInf, anyZero, nanResult;
  fpStrobe_t freshStrobe;
  fpStrobe_t strobePipe [STAGES];

  always_comb begin
    anyNan  = (classA == CLS_QNAN) || (classA == CLS_SNAN) ||
              (classB == CLS_QNAN) || (classB == CLS_SNAN);
    anySnan = (classA == CLS_SNAN) || (classB == CLS_SNAN);
    anyInf  = (classA == CLS_INF)  || (classB == CLS_INF);
    anyZero = (classA == CLS_ZERO) || (classB == CLS_ZERO);
    nanResult = anyNan || (anyInf && anyZero);
    freshStrobe.forceNan     = nanResult;
    freshStrobe.forceInf     = anyInf && !nanResult;
    freshStrobe.forceZero    = anyZero && !nanResult;
    freshStrobe.raiseInvalid = anySnan || (anyInf && anyZero);
  end

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       strobePipe[g] <= '0;
      else if (g == 0) strobePipe[g] <= freshStrobe;
      else             strobePipe[g] <= strobePipe[(g == 0) ? 0 : g-1];
    end
  end

  assign strobeOut = strobePipe[STAGES-1];

  // Zero times infinity must be flagged invalid one stage later (R8)
  assert_zero_inf_invalid_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((classA == CLS_ZERO && classB == CLS_INF) || (classA == CLS_INF && classB == CLS_ZERO))
      |=> (strobePipe[0].forceNan && strobePipe[0].raiseInvalid));

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [EXP_W+FRAC_W:0]   aIn,
  input  logic [EXP_W+FRAC_W:0]   bIn,
  input  fpStrobe_t               strobeIn,
  output logic [EXP_W+FRAC_W:0]   dataOut,
  output logic                    ovfOut,
  output logic                    udfOut,
  output logic                    invOut
);

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MAG_W   = EXP_W + FRAC_W;
  localparam int MAN_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * MAN_W;
  localparam int EXT_W   = EXP_W + 3;
  localparam int LZ_W    = $clog2(MAN_W + 1);
  localparam int SH_W    = $clog2(PROD_W + 1);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int SIGN_STAGES = PIPE_DEPTH - 1;

  localparam logic signed [EXT_W-1:0] BIAS_X   = EXT_W'(BIAS);
  localparam logic signed [EXT_W-1:0] ONE_X    = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MAXEXP_X = EXT_W'(EXP_MAX);
  localparam logic signed [EXT_W-1:0] PROD_X   = EXT_W'(PROD_W);
  localparam logic [MAG_W-1:0]  INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [LZ_W-1:0] countLead(input logic [MAN_W-1:0] v);
    countLead = LZ_W'(MAN_W);
    for (int i = 0; i < MAN_W; i++)
      if (v[i]) countLead = LZ_W'(MAN_W - 1 - i);
  endfunction

  logic [WORD_W-1:0] opWord [2];
  assign opWord[0] = aIn;
  assign opWord[1] = bIn;

  logic [SIGN_STAGES-1:0] sgnPipe;

  // Stage 1: unpack
  logic signed [EXT_W-1:0] s1Exp [2];
  logic [MAN_W-1:0]        s1Man [2];
  // Stage 2: subnormal significands normalized
  logic signed [EXT_W-1:0] s2Exp [2];
  logic [MAN_W-1:0]        s2Man [2];
  // Stage 3: exponent sum and raw product
  logic signed [EXT_W-1:0] s3Exp;
  logic [PROD_W-1:0]       s3Prod;
  // Stage 4: product normalized with leading one at the top bit
  logic signed [EXT_W-1:0] s4Exp;
  logic [PROD_W-1:0]       s4Sig;
  // Stage 5: tiny results shifted into subnormal range
  logic [EXP_W-1:0]        s5Exp;
  logic [PROD_W-2:0]       s5Sig;
  logic                    s5Sticky, s5Ovf;
  // Stage 6: rounded magnitude
  logic [MAG_W-1:0]        s6Mag;
  logic                    s6Inexact, s6Ovf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgnPipe <= '0;
      for (int k = 0; k < 2; k++) begin
        s1Exp[k] <= '0; s1Man[k] <= '0;
        s2Exp[k] <= '0; s2Man[k] <= '0;
      end
    end else begin
      sgnPipe <= {sgnPipe[SIGN_STAGES-2:0], aIn[WORD_W-1] ^ bIn[WORD_W-1]};
      for (int k = 0; k < 2; k++) begin
        if (opWord[k][MAG_W-1 -: EXP_W] == '0)
          s1Exp[k] <= ONE_X;
        else
          s1Exp[k] <= $signed({{(EXT_W-EXP_W){1'b0}}, opWord[k][MAG_W-1 -: EXP_W]});
        s1Man[k] <= {opWord[k][MAG_W-1 -: EXP_W] != '0, opWord[k][FRAC_W-1:0]};
        s2Man[k] <= s1Man[k] << countLead(s1Man[k]);
        s2Exp[k] <= s1Exp[k] - $signed({{(EXT_W-LZ_W){1'b0}}, countLead(s1Man[k])});
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3Exp <= '0; s3Prod <= '0;
      s4Exp <= '0; s4Sig <= '0;
    end else begin
      s3Exp  <= s2Exp[0] + s2Exp[1] - BIAS_X;
      s3Prod <= PROD_W'(s2Man[0]) * PROD_W'(s2Man[1]);
      if (s3Prod[PROD_W-1]) begin
        s4Sig <= s3Prod;
        s4Exp <= s3Exp + ONE_X;
      end else begin
        s4Sig <= s3Prod << 1;
        s4Exp <= s3Exp;
      end
    end
  end

  // Denormalizing shift
  logic                    isTiny, isHuge, lostBits;
  logic signed [EXT_W-1:0] shAmt;
  logic [SH_W-1:0]         shClamp;
  logic [PROD_W-2:0]       shiftedSig;

  always_comb begin
    isTiny     = s4Exp < ONE_X;
    isHuge     = s4Exp >= MAXEXP_X;
    shAmt      = ONE_X - s4Exp;
    shClamp    = (shAmt > PROD_X) ? SH_W'(PROD_W) : shAmt[SH_W-1:0];
    shiftedSig = (PROD_W-1)'(s4Sig >> shClamp);
    lostBits   = |(s4Sig & ~({PROD_W{1'b1}} << shClamp));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s5Exp <= '0; s5Sig <= '0; s5Sticky <= 1'b0; s5Ovf <= 1'b0;
    end else begin
      s5Sig    <= isTiny ? shiftedSig : s4Sig[PROD_W-2:0];
      s5Exp    <= isTiny ? '0 : s4Exp[EXP_W-1:0];
      s5Sticky <= isTiny && lostBits;
      s5Ovf    <= isHuge;
    end
  end

  // Round to nearest, ties to even
  logic             lsbBit, guardBit, restBits, incBit;
  logic [MAG_W-1:0] roundedMag;

  always_comb begin
    lsbBit     = s5Sig[PROD_W-MAN_W];
    guardBit   = s5Sig[PROD_W-MAN_W-1];
    restBits   = (|s5Sig[PROD_W-MAN_W-2:0]) || s5Sticky;
    incBit     = guardBit && (restBits || lsbBit);
    roundedMag = {s5Exp, s5Sig[PROD_W-2 -: FRAC_W]} + MAG_W'(incBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s6Mag <= '0; s6Inexact <= 1'b0; s6Ovf <= 1'b0;
    end else begin
      s6Mag     <= roundedMag;
      s6Inexact <= guardBit || restBits;
      s6Ovf     <= s5Ovf || (roundedMag[MAG_W-1 -: EXP_W] == '1);
    end
  end

  // Stage 7: merge with control decision, register outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0; ovfOut <= 1'b0; udfOut <= 1'b0; invOut <= 1'b0;
    end else begin
      ovfOut <= 1'b0;
      udfOut <= 1'b0;
      invOut <= strobeIn.raiseInvalid;
      if (strobeIn.forceNan)       dataOut <= QNAN;
      else if (strobeIn.forceInf)  dataOut <= {sgnPipe[SIGN_STAGES-1], INF_MAG};
      else if (strobeIn.forceZero) dataOut <= {sgnPipe[SIGN_STAGES-1], {MAG_W{1'b0}}};
      else if (s6Ovf) begin
        dataOut <= {sgnPipe[SIGN_STAGES-1], INF_MAG};
        ovfOut  <= 1'b1;
      end else begin
        dataOut <= {sgnPipe[SIGN_STAGES-1], s6Mag};
        udfOut  <= s6Inexact && (s6Mag[MAG_W-1 -: EXP_W] == '0);
      end
    end
  end

  assert_ovf_is_inf_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut |-> (dataOut[MAG_W-1:0] == INF_MAG));
  assert_invalid_is_qnan_R7: assert property (@(posedge clk) disable iff (!rstN)
    invOut |-> (dataOut == QNAN));
  assert_udf_zero_exp_R5: assert property (@(posedge clk) disable iff (!rstN)
    udfOut |-> (dataOut[MAG_W-1 -: EXP_W] == '0));
  assert_no_ovf_with_udf_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfOut && udfOut));

endmodule

// File: rtl/fp32_mul_pipe.sv
module fp32_mul_pipe
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EXP_W+FRAC_W:0] aIn,
  input  logic [EXP_W+FRAC_W:0] bIn,
  output logic [EXP_W+FRAC_W:0] productOut,
  output logic                  overflowOut,
  output logic                  underflowOut,
  output logic                  invalidOut
);

  localparam int MAG_W = EXP_W + FRAC_W;

  fpClass_e  opClass [2];
  fpStrobe_t ctrlStrobe;

  for (genvar k = 0; k < 2; k++) begin : gClassify
    fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
      .magIn   ((k == 0) ? aIn[MAG_W-1:0] : bIn[MAG_W-1:0]),
      .opClass (opClass[k])
    );
  end

  fpm_ctrl #(.STAGES(PIPE_DEPTH - 1)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .classA    (opClass[0]),
    .classB    (opClass[1]),
    .strobeOut (ctrlStrobe)
  );

  fpm_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .aIn      (aIn),
    .bIn      (bIn),
    .strobeIn (ctrlStrobe),
    .dataOut  (productOut),
    .ovfOut   (overflowOut),
    .udfOut   (underflowOut),
    .invOut   (invalidOut)
  );

  // Edges since reset, saturating, so the latency check never looks before reset
  logic [2:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != '1) warmCnt <= warmCnt + 3'd1;
  end

  assert_nan_after_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == '1) && $past(aIn[MAG_W-1 -: EXP_W] == '1 && aIn[FRAC_W-1:0] != '0, 7)
      |-> (productOut == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

endmodule

// File: tb/fp32_mul_pipe_tb.sv
module fp32_mul_pipe_tb;

  localparam int NV  = 26;
  localparam int LAT = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] aIn = '0, bIn = '0;
  logic [31:0] productOut;
  logic        overflowOut, underflowOut, invalidOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  fp32_mul_pipe u_dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .productOut(productOut), .overflowOut(overflowOut),
    .underflowOut(underflowOut), .invalidOut(invalidOut)
  );

  // {a, b, expected product, expected {ovf,udf,inv}, requirement number}
  localparam logic [102:0] VECS [NV] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000, 4'd2},  // R2 1*1
    {32'h40000000, 32'h40400000, 32'h40C00000, 3'b000, 4'd2},  // R2 2*3
    {32'hBFC00000, 32'h40000000, 32'hC0400000, 3'b000, 4'd3},  // R3 -1.5*2
    {32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000, 4'd2},  // R2 below half
    {32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, 4'd2},  // R2 tie up to even
    {32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, 4'd2},  // R2 tie stays even
    {32'h7F7FFFFF, 32'h40000000, 32'h7F800000, 3'b100, 4'd6},  // R6
    {32'hFF7FFFFF, 32'h40000000, 32'hFF800000, 3'b100, 4'd6},  // R6 negative
    {32'h00000001, 32'h4B000000, 32'h00800000, 3'b000, 4'd4},  // R4
    {32'h00400000, 32'h40000000, 32'h00800000, 3'b000, 4'd4},  // R4
    {32'h00800000, 32'h3F000000, 32'h00400000, 3'b000, 4'd5},  // R5 exact subnormal
    {32'h00000001, 32'h3F000000, 32'h00000000, 3'b010, 4'd5},  // R5 tie to zero
    {32'h00000003, 32'h3F000000, 32'h00000002, 3'b010, 4'd5},  // R5 tie to even
    {32'h00000001, 32'hBF400000, 32'h80000001, 3'b010, 4'd5},  // R5 round up
    {32'h007FFFFF, 32'h3F800001, 32'h00800000, 3'b000, 4'd5},  // R5 rounds to min normal
    {32'h00000001, 32'h00000001, 32'h00000000, 3'b010, 4'd5},  // R5 deep underflow
    {32'h7F800000, 32'h3F800000, 32'h7F800000, 3'b000, 4'd9},  // R9
    {32'h7F800000, 32'h80000000, 32'h7FC00000, 3'b001, 4'd8},  // R8
    {32'h7FC00000, 32'h3F800000, 32'h7FC00000, 3'b000, 4'd7},  // R7 quiet
    {32'h7F800001, 32'h3F800000, 32'h7FC00000, 3'b001, 4'd7},  // R7 signaling
    {32'h80000000, 32'h3F800000, 32'h80000000, 3'b000, 4'd3},  // R3 signed zero
    {32'h00000000, 32'h7F7FFFFF, 32'h00000000, 3'b000, 4'd9},  // R9
    {32'hFF800000, 32'hC0000000, 32'h7F800000, 3'b000, 4'd3},  // R3 -inf*-2
    {32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000, 4'd2},  // R2 large
    {32'hFFC00000, 32'h00000000, 32'h7FC00000, 3'b000, 4'd7},  // R7 quiet NaN * 0
    {32'h80000001, 32'h00000001, 32'h80000000, 3'b010, 4'd3}   // R3 negative zero
  };

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input int req, input logic [31:0] expData, input logic [2:0] expFlags);
    logic [2:0] actFlags;
    actFlags = {overflowOut, underflowOut, invalidOut};
    checks++;
    if (productOut !== expData || actFlags !== expFlags) begin
      fails++;
      $display("FAIL R%0d: got %h flags %b, expected %h flags %b",
               req, productOut, actFlags, expData, expFlags);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: cycles %0d, expected under 20000", cycles);
        finishTest();
      end
    end
  end

  initial begin : stimulus
    // R10: reset state
    repeat (3) @(negedge clk);
    check(10, 32'h0, 3'b000);
    rstN = 1'b1;

    // R1 and table: back-to-back stream, result 7 edges after capture
    for (int cyc = 0; cyc < NV + LAT; cyc++) begin
      @(negedge clk);
      if (cyc >= LAT)
        check(int'(VECS[cyc-LAT][3:0]), VECS[cyc-LAT][38:7], VECS[cyc-LAT][6:4]);
      if (cyc < NV) begin
        aIn = VECS[cyc][102:71];
        bIn = VECS[cyc][70:39];
      end else begin
        aIn = '0;
        bIn = '0;
      end
    end

    // R1: single operation among zeros, exact latency
    repeat (LAT) @(negedge clk);
    aIn = 32'h3F800000;
    bIn = 32'h40000000;
    @(negedge clk);
    aIn = '0;
    bIn = '0;
    repeat (LAT - 2) @(negedge clk);
    check(1, 32'h00000000, 3'b000);   // R1 one edge early
    @(negedge clk);
    check(1, 32'h40000000, 3'b000);   // R1 on time
    @(negedge clk);
    check(1, 32'h00000000, 3'b000);   // R1 one edge late

    // R10: reset while an overflowing product is in flight
    aIn = 32'h7F7FFFFF;
    bIn = 32'h40000000;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(10, 32'h00000000, 3'b000);
    rstN = 1'b1;
    aIn = '0;
    bIn = '0;
    repeat (LAT + 1) @(negedge clk);
    check(10, 32'h00000000, 3'b000);

    finishTest();
  end

endmodule